// File: doc/BRIEF.md
# Sector DMA Disk Controller

This block is a block-storage controller mapped into a 32-bit register space. It holds a small internal sector store. Whole 512-byte sectors move between that store and system memory through a DMA master port. Software sets a 36-bit buffer address, split over a low word and a 4-bit high field, and a linear sector number. It then writes a command word that starts a transfer from the sector to memory or from memory to the sector, or clears a pending interrupt.

A transfer moves 128 consecutive 32-bit words. The memory address rises by four after each accepted beat. When the last beat is accepted, the controller drops busy, latches an interrupt-pending flag and holds its interrupt line high until software clears it. Bad commands perform no transfer and set an error flag. These are a command that asks for both directions at once, and a command that names a sector outside the store. Reads of the status register show busy, error and interrupt-pending. The disk size in bytes is derived from the sector-count parameter and is read-only.

Top module: `blk_dma_ctrl`

## Requirements
- R1: The buffer-address low word (offset 0x00) and the sector number (offset 0x04) read back the last value written. The buffer-address high register (offset 0x10) keeps only bits 3:0 of the written value and reads zero above them.
- R2: The disk-size low word (offset 0x0C) reads SECTORS*512, and writes to it have no effect. The disk-size high word (offset 0x18) and the spare word (offset 0x14) read zero.
- R3: The status word (offset 0x08) has busy at bit 4, error at bit 3 and interrupt-pending at bit 2, and reads zero in every other bit. After reset it reads 0 and the interrupt output is low.
- R4: A command with only bit 1 set copies memory into the addressed sector. It makes 128 read beats (dma_we low), the first at the programmed 36-bit address, each later one 4 above the previous.
- R5: A command with only bit 0 set copies the addressed sector into memory with 128 write beats (dma_we high) over the same address sequence. The words that reach memory equal those last stored into that sector.
- R6: After the last beat, busy reads 0, interrupt-pending reads 1 and irq stays high until a command with bit 2 set is accepted. That command clears both.
- R7: A command with bits 0 and 1 both set makes no DMA request, sets the error flag and leaves interrupt-pending unchanged.
- R8: A read or write command whose sector number is at or above SECTORS makes no DMA request, sets error and sets interrupt-pending.
- R9: A command written while busy is reads 1 has no effect on the error flag, the interrupt flag or the transfer in progress.
- R10: An accepted, in-range read or write command clears the error flag and sets busy in the status read one cycle after the write.
- R11: While dma_req is high and dma_ready is low, dma_req stays high on the next cycle and dma_addr keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dma_req | output | 1 | DMA beat request |
| dma_we | output | 1 | 1 = beat writes memory, 0 = beat reads memory |
| dma_addr | output | 36 | Byte address of the beat |
| dma_wdata | output | 32 | Data for a memory-write beat |
| dma_ready | input | 1 | Memory accepts the current beat |
| dma_rdata | input | 32 | Memory data for a read beat, valid with dma_ready |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions assume the memory side keeps to the request/ready rule. That means read data is valid in the same cycle as dma_ready, and dma_ready carries no meaning while no request is out. They also assume that software accesses each register only with a one-cycle strobe and word-aligned offsets. The bench drives the register strobe for one cycle at a falling edge and always uses aligned offsets. Its memory model returns data combinationally from the request address. It produces dma_ready from a free-running stall pattern, so the hold rule gets exercised and the protocol is never broken.

// File: rtl/dskc_pkg.sv
package dskc_pkg;
    localparam int unsigned WORD_W       = 32;
    localparam int unsigned ADDR_W       = 36;
    localparam int unsigned SECTOR_BYTES = 512;
    localparam int unsigned BEATS        = SECTOR_BYTES / (WORD_W / 8);
    localparam int unsigned BEAT_W       = $clog2(BEATS);

    // register index = byte offset / 4
    typedef enum logic [2:0] {
        RG_BUF_LO  = 3'd0,
        RG_SECTOR  = 3'd1,
        RG_CTRL    = 3'd2,
        RG_SIZE_LO = 3'd3,
        RG_BUF_HI  = 3'd4,
        RG_SPARE   = 3'd5,
        RG_SIZE_HI = 3'd6
    } reg_idx_e;

    localparam int unsigned ST_BUSY = 4;
    localparam int unsigned ST_ERR  = 3;
    localparam int unsigned ST_IRQ  = 2;

    localparam int unsigned CMD_RD  = 0;
    localparam int unsigned CMD_WR  = 1;
    localparam int unsigned CMD_CLR = 2;

    typedef enum logic {
        SQ_IDLE,
        SQ_MOVE
    } sq_state_e;
endpackage

// File: rtl/dskc_store.sv
module dskc_store #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned IDX_W = 9,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/dskc_seq.sv
module dskc_seq
    import dskc_pkg::*;
#(
    parameter int unsigned SECT_W = 2,
    parameter int unsigned IDX_W  = SECT_W + BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              to_disk_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [WORD_W-1:0] sector_i,
    output logic              dma_req_o,
    output logic              dma_we_o,
    output logic [ADDR_W-1:0] dma_addr_o,
    output logic [WORD_W-1:0] dma_wdata_o,
    input  logic              dma_ready_i,
    input  logic [WORD_W-1:0] dma_rdata_i,
    output logic [IDX_W-1:0]  st_idx_o,
    output logic              st_we_o,
    output logic [WORD_W-1:0] st_wdata_o,
    input  logic [WORD_W-1:0] st_rdata_i,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        sq_state_e         state;
        logic              to_disk;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] beat;
        logic [SECT_W-1:0] sect;
    } seq_t;

    seq_t s_q, s_d;

    logic unused_sector_hi;
    assign unused_sector_hi = ^sector_i;

    always_comb begin
        s_d     = s_q;
        done_o  = 1'b0;
        st_we_o = 1'b0;
        unique case (s_q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    s_d.state   = SQ_MOVE;
                    s_d.to_disk = to_disk_i;
                    s_d.addr    = base_i;
                    s_d.beat    = '0;
                    s_d.sect    = sector_i[SECT_W-1:0];
                end
            end
            SQ_MOVE: begin
                if (dma_ready_i) begin
                    st_we_o  = s_q.to_disk;
                    s_d.addr = s_q.addr + ADDR_W'(4);
                    s_d.beat = s_q.beat + 1'b1;
                    if (s_q.beat == LAST_BEAT) begin
                        s_d.state = SQ_IDLE;
                        done_o    = 1'b1;
                    end
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: SQ_IDLE, to_disk: 1'b0, addr: '0, beat: '0, sect: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign dma_req_o   = (s_q.state == SQ_MOVE);
    assign dma_we_o    = ~s_q.to_disk;
    assign dma_addr_o  = s_q.addr;
    assign dma_wdata_o = st_rdata_i;
    assign st_idx_o    = {s_q.sect, s_q.beat};
    assign st_wdata_o  = dma_rdata_i;
    assign busy_o      = (s_q.state == SQ_MOVE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o && !dma_ready_i |=> dma_req_o && $stable(dma_addr_o)); // R11

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o && dma_ready_i && (s_q.beat != LAST_BEAT)
        |=> dma_req_o && (dma_addr_o == $past(dma_addr_o) + ADDR_W'(4))); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R6
endmodule

// File: rtl/dskc_regs.sv
module dskc_regs
    import dskc_pkg::*;
#(
    parameter int unsigned SECTORS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid_i,
    input  logic              reg_we_i,
    input  logic [4:0]        reg_addr_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    output logic              start_o,
    output logic              to_disk_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [WORD_W-1:0] sector_o,
    output logic              irq_o
);
    localparam logic [63:0] DISK_BYTES = 64'(SECTORS) * 64'(SECTOR_BYTES);

    typedef struct packed {
        logic [WORD_W-1:0]        buf_lo;
        logic [ADDR_W-WORD_W-1:0] buf_hi;
        logic [WORD_W-1:0]        sector;
        logic                     err;
        logic                     irq;
    } regs_t;

    regs_t r_q, r_d;

    logic     wr_en;
    logic     cmd_wr;
    reg_idx_e idx;
    logic     unused_addr_lo;

    assign idx            = reg_idx_e'(reg_addr_i[4:2]);
    assign wr_en          = reg_valid_i && reg_we_i;
    assign cmd_wr         = wr_en && (idx == RG_CTRL);
    assign unused_addr_lo = ^reg_addr_i[1:0];

    always_comb begin
        r_d       = r_q;
        start_o   = 1'b0;
        to_disk_o = reg_wdata_i[CMD_WR];
        if (wr_en) begin
            case (idx)
                RG_BUF_LO: r_d.buf_lo = reg_wdata_i;
                RG_SECTOR: r_d.sector = reg_wdata_i;
                RG_BUF_HI: r_d.buf_hi = reg_wdata_i[ADDR_W-WORD_W-1:0];
                RG_CTRL: begin
                    if (!busy_i) begin
                        if (reg_wdata_i[CMD_CLR]) begin
                            r_d.irq = 1'b0;
                        end
                        if (reg_wdata_i[CMD_RD] && reg_wdata_i[CMD_WR]) begin
                            r_d.err = 1'b1;
                        end else if (reg_wdata_i[CMD_RD] || reg_wdata_i[CMD_WR]) begin
                            if (r_q.sector >= WORD_W'(SECTORS)) begin
                                r_d.err = 1'b1;
                                r_d.irq = 1'b1;
                            end else begin
                                r_d.err = 1'b0;
                                start_o = 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
        if (done_i) begin
            r_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (idx)
            RG_BUF_LO:  reg_rdata_o = r_q.buf_lo;
            RG_SECTOR:  reg_rdata_o = r_q.sector;
            RG_CTRL: begin
                reg_rdata_o[ST_BUSY] = busy_i;
                reg_rdata_o[ST_ERR]  = r_q.err;
                reg_rdata_o[ST_IRQ]  = r_q.irq;
            end
            RG_SIZE_LO: reg_rdata_o = DISK_BYTES[31:0];
            RG_BUF_HI:  reg_rdata_o = WORD_W'(r_q.buf_hi);
            RG_SIZE_HI: reg_rdata_o = DISK_BYTES[63:32];
            default:    reg_rdata_o = '0;
        endcase
    end

    assign base_o   = {r_q.buf_hi, r_q.buf_lo};
    assign sector_o = r_q.sector;
    assign irq_o    = r_q.irq;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.irq && !(cmd_wr && reg_wdata_i[CMD_CLR]) |=> r_q.irq); // R6

    AST_BUSY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && busy_i |=> $stable(r_q.err)); // R9

    AST_DUAL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !busy_i && reg_wdata_i[CMD_RD] && reg_wdata_i[CMD_WR]
        |=> r_q.err && !busy_i); // R7

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> busy_i && !r_q.err); // R10
endmodule

// File: rtl/blk_dma_ctrl.sv
module blk_dma_ctrl
    import dskc_pkg::*;
#(
    parameter int unsigned SECTORS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_valid,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        dma_req,
    output logic        dma_we,
    output logic [35:0] dma_addr,
    output logic [31:0] dma_wdata,
    input  logic        dma_ready,
    input  logic [31:0] dma_rdata,
    output logic        irq
);
    localparam int unsigned SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;
    localparam int unsigned IDX_W  = SECT_W + BEAT_W;
    localparam int unsigned DEPTH  = 1 << IDX_W;

    logic              start;
    logic              to_disk;
    logic [ADDR_W-1:0] base;
    logic [WORD_W-1:0] sector;
    logic              busy;
    logic              done;
    logic [IDX_W-1:0]  st_idx;
    logic              st_we;
    logic [WORD_W-1:0] st_wdata;
    logic [WORD_W-1:0] st_rdata;

    dskc_regs #(.SECTORS(SECTORS)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_valid_i (reg_valid),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .busy_i      (busy),
        .done_i      (done),
        .start_o     (start),
        .to_disk_o   (to_disk),
        .base_o      (base),
        .sector_o    (sector),
        .irq_o       (irq)
    );

    dskc_seq #(.SECT_W(SECT_W), .IDX_W(IDX_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .to_disk_i   (to_disk),
        .base_i      (base),
        .sector_i    (sector),
        .dma_req_o   (dma_req),
        .dma_we_o    (dma_we),
        .dma_addr_o  (dma_addr),
        .dma_wdata_o (dma_wdata),
        .dma_ready_i (dma_ready),
        .dma_rdata_i (dma_rdata),
        .st_idx_o    (st_idx),
        .st_we_o     (st_we),
        .st_wdata_o  (st_wdata),
        .st_rdata_i  (st_rdata),
        .busy_o      (busy),
        .done_o      (done)
    );

    dskc_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DW(WORD_W)) i_store (
        .clk     (clk),
        .we_i    (st_we),
        .idx_i   (st_idx),
        .wdata_i (st_wdata),
        .rdata_o (st_rdata)
    );
endmodule

// File: tb/test_blk_dma_ctrl.sv
module test_blk_dma_ctrl;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned SECTORS    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dma_req;
    logic        dma_we;
    logic [35:0] dma_addr;
    logic [31:0] dma_wdata;
    logic        dma_ready = 1'b0;
    logic [31:0] dma_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;

    blk_dma_ctrl #(.SECTORS(SECTORS)) i_blk_dma_ctrl (
        .clk, .rst_n, .reg_valid, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .dma_req, .dma_we, .dma_addr, .dma_wdata, .dma_ready, .dma_rdata, .irq
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // memory model
    logic [31:0] bmem [0:511];
    logic [35:0] exp_addr;
    logic        exp_we;
    int          beats = 0;
    int          addr_err = 0;
    int          we_err = 0;
    int          hold_err = 0;
    logic        was_stall = 1'b0;
    logic [35:0] stall_addr;
    int          stall_mod = 3;
    int          cyc = 0;

    assign dma_rdata = bmem[dma_addr[10:2]];

    always @(negedge clk) begin
        cyc       <= cyc + 1;
        dma_ready <= ((cyc % stall_mod) != 0);
    end

    always @(posedge clk) begin
        if (was_stall && (!dma_req || dma_addr != stall_addr)) hold_err++;
        was_stall  <= dma_req && !dma_ready;
        stall_addr <= dma_addr;
        if (dma_req && dma_ready) begin
            if (dma_addr != exp_addr) addr_err++;
            if (dma_we != exp_we) we_err++;
            if (dma_we) bmem[dma_addr[10:2]] <= dma_wdata;
            exp_addr <= exp_addr + 36'd4;
            beats++;
        end
    end

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_valid = 1'b1; reg_we = 1'b0;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, {35'd0, irq}, 36'd1);
    endtask

    // {offset, write data, expected read}
    localparam logic [68:0] VEC [0:7] = '{
        {5'h00, 32'h1234_5678, 32'h1234_5678},  // R1
        {5'h04, 32'h0000_0003, 32'h0000_0003},  // R1
        {5'h10, 32'hFFFF_FFFA, 32'h0000_000A},  // R1
        {5'h0C, 32'hDEAD_BEEF, 32'h0000_0800},  // R2
        {5'h14, 32'h5555_5555, 32'h0000_0000},  // R2
        {5'h18, 32'h0000_0001, 32'h0000_0000},  // R2
        {5'h00, 32'h0000_0000, 32'h0000_0000},  // R1
        {5'h10, 32'h0000_0009, 32'h0000_0009}   // R1
    };

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int mism;
        for (int i = 0; i < 512; i++) bmem[i] = 32'hA500_0000 + 32'(i * 7);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(5'h08, v); chk("R3 reset status", 36'(v), 36'h0);
        chk("R3 reset irq", {35'd0, irq}, 36'd0);
        chk("R3 reset req", {35'd0, dma_req}, 36'd0);

        foreach (VEC[i]) begin
            wr(VEC[i][68:64], VEC[i][63:32]);
            rd(VEC[i][68:64], v);
            chk((VEC[i][68:64] inside {5'h0C, 5'h14, 5'h18}) ? "R2 table" : "R1 table",
                36'(v), 36'(VEC[i][31:0]));
        end

        // R4: memory -> sector 2 from 0x9_0000_0000
        wr(5'h04, 32'd2);
        exp_addr = 36'h9_0000_0000; exp_we = 1'b0; beats = 0;
        wr(5'h08, 32'h2);
        rd(5'h08, v); chk("R10 busy after start", 36'(v), 36'h10);
        wait_irq("R6 irq after write cmd");
        chk("R4 beats", 36'(beats), 36'd128);
        chk("R4 addresses", 36'(addr_err), 36'd0);
        chk("R4 dma_we low", 36'(we_err), 36'd0);
        rd(5'h08, v); chk("R6 status done", 36'(v), 36'h04);
        repeat (10) @(negedge clk);
        chk("R6 irq held", {35'd0, irq}, 36'd1);
        wr(5'h08, 32'h4);
        chk("R6 irq cleared", {35'd0, irq}, 36'd0);
        rd(5'h08, v); chk("R6 status cleared", 36'(v), 36'h0);

        // R5: sector 2 -> 0x9_0000_0200
        for (int i = 128; i < 256; i++) bmem[i] = 32'h0;
        wr(5'h00, 32'h200);
        exp_addr = 36'h9_0000_0200; exp_we = 1'b1; beats = 0; addr_err = 0;
        wr(5'h08, 32'h1);
        wait_irq("R5 irq after read cmd");
        chk("R5 beats", 36'(beats), 36'd128);
        chk("R5 addresses", 36'(addr_err), 36'd0);
        chk("R5 dma_we high", 36'(we_err), 36'd0);
        mism = 0;
        for (int i = 0; i < 128; i++) if (bmem[128 + i] !== bmem[i]) mism++;
        chk("R5 data", 36'(mism), 36'd0);
        wr(5'h08, 32'h4);

        // R7: both direction bits
        beats = 0;
        wr(5'h08, 32'h3);
        repeat (20) @(negedge clk);
        rd(5'h08, v); chk("R7 status", 36'(v), 36'h08);
        chk("R7 no beats", 36'(beats), 36'd0);
        chk("R7 irq low", {35'd0, irq}, 36'd0);

        // R8: sector out of range
        wr(5'h04, SECTORS);
        wr(5'h08, 32'h1);
        repeat (20) @(negedge clk);
        rd(5'h08, v); chk("R8 status", 36'(v), 36'h0C);
        chk("R8 no beats", 36'(beats), 36'd0);
        chk("R8 irq high", {35'd0, irq}, 36'd1);
        wr(5'h08, 32'h4);
        rd(5'h08, v); chk("R8 err kept after clear", 36'(v), 36'h08);

        // R9, R10: commands while busy, slow memory
        stall_mod = 2;
        wr(5'h04, 32'd2);
        wr(5'h00, 32'h400);
        exp_addr = 36'h9_0000_0400; exp_we = 1'b1; beats = 0; addr_err = 0;
        wr(5'h08, 32'h1);
        rd(5'h08, v); chk("R10 err cleared by start", 36'(v), 36'h10);
        wr(5'h08, 32'h3);
        wr(5'h08, 32'h6);
        rd(5'h08, v); chk("R9 busy cmds ignored", 36'(v), 36'h10);
        wait_irq("R9 transfer completes");
        rd(5'h08, v); chk("R9 status after", 36'(v), 36'h04);
        chk("R9 beats", 36'(beats), 36'd128);
        chk("R11 hold during stall", 36'(hold_err), 36'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule